// File: doc/BRIEF.md
# Shared Prescaler Tick Generator

This block turns one fast clock into five independent tick-enable strobes for a bank of timer channels. Two 8-bit prescalers divide the clock first. The first prescaler feeds channels 0 and 1, and the second feeds channels 2, 3 and 4. Each channel then divides its prescaler strobe by a power of two that it selects for itself. A channel therefore ticks once every (prescale + 1) × 2^select clock cycles.

Software sets the block up through two 32-bit configuration words on a small write/read port. The prescale word holds both prescale values. The divide word holds one 4-bit select field per channel. Both words read back exactly as written.

New values take effect on the running counters without a reset. A prescaler picks up its new value when it next reloads, and a post-divider picks up its new select on its next strobe. The counters that the ticks enable, the interrupts and the waveform logic are not part of this block.

Top module: `tick_prescaler`

## Requirements
- R1: After reset the prescale word reads 0x0000_0101 and the divide word reads 0. While reset is held every tick is low. With the reset configuration every channel ticks once every 2 cycles.
- R2: A write with `wr_en` high stores all 32 bits of `wr_data`. It goes into the prescale word when `wr_sel` is 0 and into the divide word when `wr_sel` is 1. From the next cycle, `rd_data` returns that value for the same `rd_sel`.
- R3: Prescaler 0 takes its value from prescale word bits [7:0] and drives channels 0 and 1. Prescaler 1 takes its value from bits [15:8] and drives channels 2, 3 and 4.
- R4: Channel n takes its select value s from divide word bits [4n+3:4n].
- R5: Once settled, channel n ticks exactly every (p+1) × 2^s clock cycles, where p is the value of its prescaler.
- R6: A select value above MAX_SEL (default 4) behaves as MAX_SEL, giving a post-divide of 2^MAX_SEL.
- R7: When the interval is longer than one cycle, each tick is a single-cycle pulse. When p = 0 and s = 0, the tick stays high on every cycle.
- R8: Two channels that share a prescaler and have equal effective select values tick in exactly the same cycles.
- R9: Rewriting either word while the block runs needs no reset. From the second tick after the write onward, each channel keeps the new interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one configuration word |
| wr_sel | input | 1 | Word written: 0 prescale word, 1 divide word |
| wr_data | input | 32 | Write value |
| rd_sel | input | 1 | Word read: 0 prescale word, 1 divide word |
| rd_data | output | 32 | Contents of the selected word |
| tick | output | 5 | One tick-enable strobe per channel |

## Verification
The hardest state to reach from the ports is a steady interval after the configuration has changed underneath counters that are already running. Just after a write, the prescaler finishes its old countdown and the post-divider resumes from an arbitrary phase, so the first new interval is irregular. The stimulus writes both words and then lets each channel produce three ticks. It measures only the gap between the third and fourth ticks and compares it with the interval computed from the written fields. It does this for directed corners (prescale 0, prescale 255, every select value, saturated selects) and for seeded random words. The same windows also count cycles where channels that share a prescaler and have equal selects disagree.

// File: rtl/tp_pkg.sv
package tp_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_CH   = 5;
    localparam int NUM_PS   = 2;
    localparam int SPLIT_CH = 2;   // channels below this use prescaler 0
    localparam int PS_W     = 8;
    localparam int SEL_W    = 4;
    localparam int MAX_SEL  = 4;

    localparam logic [DATA_W-1:0] PRESCALE_RST = 32'h0000_0101;
    localparam logic [DATA_W-1:0] DIVSEL_RST   = 32'h0000_0000;

    typedef enum logic {
        WORD_PRESCALE = 1'b0,
        WORD_DIVSEL   = 1'b1
    } cfg_word_e;

    typedef struct packed {
        logic [DATA_W-1:0] prescale;
        logic [DATA_W-1:0] divsel;
    } cfg_words_t;

    // Prescaler index that feeds a channel
    function automatic int ps_of_ch(input int ch, input int split);
        return (ch < split) ? 0 : 1;
    endfunction

endpackage

// File: rtl/tp_cfg_regs.sv
module tp_cfg_regs
    import tp_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int NPS = NUM_PS,
    parameter int PW  = PS_W,
    parameter int SW  = SEL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rd_sel,
    output logic [DATA_W-1:0]   rd_data,
    output logic [NPS-1:0][PW-1:0] presets,
    output logic [NCH-1:0][SW-1:0] sels
);

    cfg_words_t regs_q;
    cfg_word_e  wsel, rsel;

    assign wsel = cfg_word_e'(wr_sel);
    assign rsel = cfg_word_e'(rd_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.prescale <= PRESCALE_RST;
            regs_q.divsel   <= DIVSEL_RST;
        end else if (wr_en) begin
            if (wsel == WORD_PRESCALE) regs_q.prescale <= wr_data;
            else                       regs_q.divsel   <= wr_data;
        end
    end

    always_comb begin
        rd_data = (rsel == WORD_PRESCALE) ? regs_q.prescale : regs_q.divsel;
    end

    for (genvar k = 0; k < NPS; k++) begin : g_ps_field
        assign presets[k] = regs_q.prescale[k*PW +: PW];
    end

    for (genvar n = 0; n < NCH; n++) begin : g_sel_field
        assign sels[n] = regs_q.divsel[n*SW +: SW];
    end

    AST_CFG_STORE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 1'b0) |=> (regs_q.prescale == $past(wr_data))); // R2

endmodule

// File: rtl/tp_prescaler.sv
module tp_prescaler
    import tp_pkg::*;
#(
    parameter int PW = PS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] preset,
    output logic          base
);

    logic [PW-1:0] cnt_q;

    assign base = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (base) cnt_q <= preset;
        else           cnt_q <= cnt_q - 1'b1;
    end

    AST_PS_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
        (!base && !$past(rst)) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5

endmodule

// File: rtl/tp_postdiv.sv
module tp_postdiv
    import tp_pkg::*;
#(
    parameter int SW   = SEL_W,
    parameter int MAXS = MAX_SEL
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          base,
    input  logic [SW-1:0] sel,
    output logic          tick
);

    localparam int CW = (MAXS < 1) ? 1 : MAXS;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] mask;
    logic          wrap;
    int unsigned   s_eff;

    always_comb begin
        s_eff = (int'(sel) > MAXS) ? MAXS : int'(sel);
        for (int i = 0; i < CW; i++) begin
            mask[i] = (i < s_eff);
        end
        wrap = ((cnt_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= base && wrap;
            if (base) cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TICK_FROM_BASE: assert property (@(posedge clk) disable iff (rst)
        tick |-> $past(base)); // R5

endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import tp_pkg::*;
#(
    parameter int NCH   = NUM_CH,
    parameter int SPLIT = SPLIT_CH,
    parameter int PW    = PS_W,
    parameter int SW    = SEL_W,
    parameter int MAXS  = MAX_SEL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [NCH-1:0]    tick
);

    localparam int NPS = NUM_PS;

    logic [NPS-1:0][PW-1:0] presets;
    logic [NCH-1:0][SW-1:0] sels;
    logic [NPS-1:0]         base;

    tp_cfg_regs #(.NCH(NCH), .NPS(NPS), .PW(PW), .SW(SW)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .presets (presets),
        .sels    (sels)
    );

    for (genvar k = 0; k < NPS; k++) begin : g_ps
        tp_prescaler #(.PW(PW)) u_ps (
            .clk    (clk),
            .rst    (rst),
            .preset (presets[k]),
            .base   (base[k])
        );
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        localparam int PSI = ps_of_ch(n, SPLIT);

        tp_postdiv #(.SW(SW), .MAXS(MAXS)) u_pd (
            .clk  (clk),
            .rst  (rst),
            .base (base[PSI]),
            .sel  (sels[n]),
            .tick (tick[n])
        );

        AST_PULSE_GAP: assert property (@(posedge clk) disable iff (rst)
            (tick[n] && $past(presets[PSI]) != '0) |=> !tick[n]); // R7
    end

    AST_PAIR_LOCKSTEP: assert property (@(posedge clk) disable iff (rst)
        (sels[0] == sels[1]) |=> (tick[0] == tick[1])); // R8

endmodule

// File: tb/tb_tick_prescaler.sv
`timescale 1ns/1ps
module tb_tick_prescaler;
    import tp_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic [4:0]  tick;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    tick_prescaler dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .tick(tick)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_sel(input logic [31:0] w1, input int ch);
        int s = int'(w1[ch*4 +: 4]);
        return (s > 4) ? 4 : s;
    endfunction

    function automatic int exp_iv(input logic [31:0] w0, input logic [31:0] w1, input int ch);
        int p = (ch < 2) ? int'(w0[7:0]) : int'(w0[15:8]);
        return (p + 1) << exp_sel(w1, ch);
    endfunction

    task automatic wr(input bit sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input bit sel, input logic [31:0] exp, input string req);
        @(negedge clk);
        rd_sel = sel;
        #1;
        check(rd_data === exp, req, sel ? "divide word readback" : "prescale word readback",
              longint'(rd_data), longint'(exp));
    endtask

    task automatic measure(input logic [31:0] w0, input logic [31:0] w1, input string req);
        int ev[5];
        int n[5];
        int t2[5];
        int t3[5];
        int mx = 1;
        int limit;
        int mis01 = 0;
        int mis_hi = 0;
        int dbl = 0;
        logic [4:0] prev = '0;
        for (int c = 0; c < 5; c++) begin
            ev[c] = exp_iv(w0, w1, c);
            n[c] = 0; t2[c] = 0; t3[c] = 0;
            if (ev[c] > mx) mx = ev[c];
        end
        limit = 5 * mx + 600;
        for (int cyc = 0; cyc < limit; cyc++) begin
            @(negedge clk);
            for (int c = 0; c < 5; c++) begin
                if (tick[c]) begin
                    n[c]++;
                    if (n[c] == 3) t2[c] = cyc;
                    if (n[c] == 4) t3[c] = cyc;
                    if (prev[c] && ev[c] > 1) dbl++;
                end
            end
            if (exp_sel(w1, 0) == exp_sel(w1, 1) && tick[0] != tick[1]) mis01++;
            if (exp_sel(w1, 2) == exp_sel(w1, 3) && tick[2] != tick[3]) mis_hi++;
            if (exp_sel(w1, 3) == exp_sel(w1, 4) && tick[3] != tick[4]) mis_hi++;
            prev = tick;
        end
        for (int c = 0; c < 5; c++) begin
            check(n[c] >= 4 && (t3[c] - t2[c]) == ev[c], req,
                  $sformatf("ch%0d tick interval", c), t3[c] - t2[c], ev[c]);
        end
        check(dbl == 0, "R7", "back-to-back ticks with interval above 1", dbl, 0);
        check(mis01 == 0 && mis_hi == 0, "R8", "shared-prescaler lockstep mismatches",
              mis01 + mis_hi, 0);
    endtask

    task automatic config_and_measure(input logic [31:0] w0, input logic [31:0] w1,
                                      input string req);
        wr(1'b0, w0);
        wr(1'b1, w1);
        rd_check(1'b0, w0, "R2");
        rd_check(1'b1, w1, "R2");
        measure(w0, w1, req);
    endtask

    initial begin
        #(5.0 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int zeros_in_reset = 0;
        void'($urandom(32'h5EED_1234));

        // R1: ticks stay low while reset is held
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (tick != 5'b0) zeros_in_reset++;
        end
        check(zeros_in_reset == 0, "R1", "ticks during reset", zeros_in_reset, 0);
        rst = 1'b0;
        rd_check(1'b0, 32'h0000_0101, "R1");
        rd_check(1'b1, 32'h0000_0000, "R1");
        measure(32'h0000_0101, 32'h0, "R1");

        // R3: prescaler 0 -> ch0/1 (p=0), prescaler 1 -> ch2..4 (p=3)
        config_and_measure(32'h0000_0300, 32'h0, "R3");
        // R4: each channel its own select field
        config_and_measure(32'h0000_0502, 32'h0004_3210, "R4");
        // R6: selects above 4 saturate
        config_and_measure(32'h0000_0201, 32'h000F_9F5F, "R6");
        // R5: largest prescale, largest unsaturated select; upper bits stored (R2)
        config_and_measure(32'hABCD_FFFF, 32'hFFF4_4444, "R5");
        // R7: p=0, s=0 everywhere -> tick high every cycle
        config_and_measure(32'h0000_0000, 32'h0, "R7");

        // R9: random reconfiguration on the fly
        for (int it = 0; it < 20; it++) begin
            logic [31:0] r0 = $urandom;
            logic [31:0] r1 = $urandom;
            r0[15:13] = 3'b0;
            r0[7:5]   = 3'b0;
            r1[3]  = r1[2] ? r1[3] : 1'b0;
            if (it % 4 == 3) r1[7:4] = r1[3:0];
            config_and_measure(r0, r1, "R9");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule